// File: doc/BRIEF.md
# Run-Time Programmable Pseudo-Random Pattern Source

This block produces a stream of pseudo-random test vectors for on-chip self-test of a combinational circuit. Its register is as wide as the circuit's input count, and each advance yields one fresh parallel vector. The serial output bit serves a scan-style consumer. Three things are fixed together by one load strobe: the shift structure (external XOR feedback or internal XOR taps), the polynomial tap mask and the starting state. Any tap set is accepted, primitive or not. Once loaded, the vector that was loaded is presented first and every later vector follows from it alone.

A one-cycle wrap pulse marks each return of the register to the state that was loaded. This makes the cycle length visible at the ports. A test controller can then confirm that a chosen polynomial and starting state give the expected period.

Top module: `lfsr_tpg`

## Requirements
- R1: While reset is high and after it is released, `vec_out` is 1 (only bit 0 set), `ser_out` is 0 and `wrap` is 0. The mask is then zero and the form is external feedback.
- R2: A cycle with `load` high makes `vec_out` equal `seed_in` after that edge. It also captures `tap_mask` and `galois_sel`. `load` takes priority over `advance` in the same cycle.
- R3: A `seed_in` of all zeros loads the value 1 instead. The register never holds all zeros.
- R4: With `galois_sel`=0, an advance shifts the vector one place toward the MSB. The new bit 0 is the XOR of every old bit k where `tap_mask[k]` is 1. Bit W-1 always takes part, whatever `tap_mask[W-1]` holds.
- R5: With `galois_sel`=1, an advance sets new bit 0 to the old MSB. For i from 1 to W-1, new bit i becomes old bit i-1 XOR (old MSB AND `tap_mask[i-1]`). `tap_mask[W-1]` has no effect.
- R6: In a cycle with neither `load` nor `advance`, `vec_out` keeps its value and `wrap` is 0.
- R7: `ser_out` always equals bit W-1 of `vec_out`.
- R8: `wrap` is high for the one cycle after an advance that brings the register back to the loaded (zero-corrected) seed. At all other times it is 0.
- R9: With W=4 and `tap_mask`=4'b1100, either form returns to the seed after exactly 15 advances. With `tap_mask`=4'b1011, the return comes after fewer than 15 advances.
- R10: Changes on `tap_mask` or `galois_sel` without `load` do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures seed, tap mask and form |
| tap_mask | input | WIDTH | Bit i-1 is polynomial coefficient i |
| seed_in | input | WIDTH | Starting state |
| galois_sel | input | 1 | 0 external XOR feedback, 1 internal XOR taps |
| advance | input | 1 | Step to the next vector |
| vec_out | output | WIDTH | Current test vector |
| ser_out | output | 1 | Output-stage bit |
| wrap | output | 1 | Pulse on return to the loaded seed |

## Verification
A wrong tap, a wrong shift direction or a lost form bit shows up on `vec_out` one cycle after the first advance where the faulty path carries a 1. The shift and feedback bits that carry the fault then spread it across later vectors. A seed register that holds the wrong value shows up as a `wrap` pulse at the wrong time, or as a missing one, within one period. Period tests therefore run through full cycles of both a primitive and a reducible polynomial in each form.

// File: rtl/lfsr_tpg_pkg.sv
`timescale 1ns/1ps
package lfsr_tpg_pkg;
  typedef enum logic {
    FORM_FIB = 1'b0,
    FORM_GAL = 1'b1
  } fb_form_e;
endpackage

// File: rtl/lfsr_step.sv
`timescale 1ns/1ps
module lfsr_step
  import lfsr_tpg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] taps,
  input  fb_form_e         form,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP_TAP = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] taps_eff;
  logic [WIDTH-1:0] fib_vec;
  logic [WIDTH-1:0] gal_vec;
  logic             out_bit;

  assign taps_eff = taps | TOP_TAP;
  assign out_bit  = cur[WIDTH-1];

  // external feedback: parity of tapped stages enters stage 0
  assign fib_vec = {cur[WIDTH-2:0], ^(cur & taps_eff)};

  // internal feedback: output stage folds into each tapped stage
  assign gal_vec[0] = out_bit;
  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_gal
      assign gal_vec[i] = cur[i-1] ^ (out_bit & taps[i-1]);
    end
  endgenerate

  always_comb begin
    nxt = (form == FORM_GAL) ? gal_vec : fib_vec;
  end
endmodule

// File: rtl/seed_guard.sv
`timescale 1ns/1ps
module seed_guard #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] safe
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    safe = (raw == '0) ? ONE : raw;
  end
endmodule

// File: rtl/wrap_detect.sv
`timescale 1ns/1ps
module wrap_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [WIDTH-1:0] cand,
  input  logic [WIDTH-1:0] origin,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst) wrap <= 1'b0;
    else     wrap <= step && (cand == origin);
  end

  p_wrap_after_step_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |-> $past(step));
endmodule

// File: rtl/lfsr_tpg.sv
`timescale 1ns/1ps
module lfsr_tpg
  import lfsr_tpg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] tap_mask,
  input  logic [WIDTH-1:0] seed_in,
  input  logic             galois_sel,
  input  logic             advance,
  output logic [WIDTH-1:0] vec_out,
  output logic             ser_out,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] state_q, seed_q, taps_q, seed_safe, state_nxt;
  fb_form_e         form_q;
  logic             step_en;

  assign step_en = advance && !load;

  seed_guard #(.WIDTH(WIDTH)) u_guard (
    .raw  (seed_in),
    .safe (seed_safe)
  );

  lfsr_step #(.WIDTH(WIDTH)) u_step (
    .cur  (state_q),
    .taps (taps_q),
    .form (form_q),
    .nxt  (state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ONE;
      seed_q  <= ONE;
      taps_q  <= '0;
      form_q  <= FORM_FIB;
    end else if (load) begin
      state_q <= seed_safe;
      seed_q  <= seed_safe;
      taps_q  <= tap_mask;
      form_q  <= fb_form_e'(galois_sel);
    end else if (advance) begin
      state_q <= state_nxt;
    end
  end

  wrap_detect #(.WIDTH(WIDTH)) u_wrap (
    .clk    (clk),
    .rst    (rst),
    .step   (step_en),
    .cand   (state_nxt),
    .origin (seed_q),
    .wrap   (wrap)
  );

  assign vec_out = state_q;
  assign ser_out = state_q[WIDTH-1];

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
    vec_out != '0);

  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> vec_out == (($past(seed_in) == '0) ? ONE : $past(seed_in)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> ($stable(vec_out) && !wrap));

  p_fib_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && form_q == FORM_FIB) |=> vec_out[WIDTH-1:1] == $past(vec_out[WIDTH-2:0]));

  p_gal_feed_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && form_q == FORM_GAL) |=> vec_out[0] == $past(ser_out));
endmodule

// File: tb/lfsr_tpg_bench.sv
`timescale 1ns/1ps
module lfsr_tpg_bench;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [BW-1:0] tap_mask = '0;
  logic [BW-1:0] seed_in = '0;
  logic          galois_sel = 1'b0;
  logic          advance = 1'b0;
  logic [BW-1:0] vec_out;
  logic          ser_out;
  logic          wrap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [BW-1:0] m_state, m_seed, m_mask;
  logic          m_gal, m_wrap;

  always #2.5 clk = ~clk;

  lfsr_tpg #(.WIDTH(BW)) u_lfsr_tpg (
    .clk(clk), .rst(rst), .load(load), .tap_mask(tap_mask), .seed_in(seed_in),
    .galois_sel(galois_sel), .advance(advance), .vec_out(vec_out),
    .ser_out(ser_out), .wrap(wrap)
  );

  function automatic logic [BW-1:0] ref_next(logic [BW-1:0] s, logic [BW-1:0] mk, logic g);
    logic [BW-1:0] r;
    logic fb;
    if (!g) begin
      fb = 1'b0;
      for (int i = 1; i <= BW; i++) if (i == BW || mk[i-1]) fb = fb ^ s[i-1];
      r = {s[BW-2:0], fb};
    end else begin
      r = {s[BW-2:0], s[BW-1]};
      if (s[BW-1]) for (int i = 1; i < BW; i++) if (mk[i-1]) r[i] = ~r[i];
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (vec_out !== m_state || ser_out !== m_state[BW-1] || wrap !== m_wrap) begin
      n_bad++;
      $display("FAIL %s: vec=%b ser=%b wrap=%b expected vec=%b ser=%b wrap=%b",
               tag, vec_out, ser_out, wrap, m_state, m_state[BW-1], m_wrap);
    end
  endtask

  task automatic step(input logic ld, input logic [BW-1:0] sd, input logic [BW-1:0] tm,
                      input logic gs, input logic adv, input string tag);
    load = ld; seed_in = sd; tap_mask = tm; galois_sel = gs; advance = adv;
    @(posedge clk);
    if (ld) begin
      m_seed = (sd == '0) ? BW'(1) : sd;
      m_state = m_seed; m_mask = tm; m_gal = gs; m_wrap = 1'b0;
    end else if (adv) begin
      m_state = ref_next(m_state, m_mask, m_gal);
      m_wrap = (m_state == m_seed);
    end else begin
      m_wrap = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int ref_period(logic [BW-1:0] sd, logic [BW-1:0] mk, logic g);
    logic [BW-1:0] s = sd;
    for (int k = 1; k <= 64; k++) begin
      s = ref_next(s, mk, g);
      if (s == sd) return k;
    end
    return -1;
  endfunction

  task automatic period_run(input logic [BW-1:0] sd, input logic [BW-1:0] mk, input logic g,
                            input bit full, input string tag);
    int seen = -1;
    int expv;
    step(1'b1, sd, mk, g, 1'b0, tag);
    for (int k = 1; k <= 40; k++) begin
      step(1'b0, '0, '0, 1'b0, 1'b1, tag);
      if (wrap && seen < 0) seen = k;
    end
    expv = full ? 15 : ref_period(sd, mk, g);
    n_chk++;
    if (seen != expv || (!full && seen >= 15)) begin
      n_bad++;
      $display("FAIL %s period: got %0d expected %0d", tag, seen, expv);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_state = 4'b0001; m_seed = 4'b0001; m_mask = '0; m_gal = 1'b0; m_wrap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset held");
    rst = 1'b0;
    step(1'b0, '0, '0, 1'b0, 1'b0, "R1 after release");

    // primitive taps 4,3 in both forms (R4, R5, R7, R8, R9)
    period_run(4'b0001, 4'b1100, 1'b0, 1'b1, "R9 R4 fib 1100");
    period_run(4'b0001, 4'b1100, 1'b1, 1'b1, "R9 R5 gal 1100");
    // reducible taps 4,2,1
    period_run(4'b0001, 4'b1011, 1'b0, 1'b0, "R9 R4 fib 1011");
    period_run(4'b0001, 4'b1011, 1'b1, 1'b0, "R9 R5 gal 1011");
    // other seed of the same cycle (R8)
    period_run(4'b1010, 4'b1100, 1'b1, 1'b1, "R8 gal seed 1010");
    // mask MSB ignored in internal form (R5)
    period_run(4'b0110, 4'b0100, 1'b1, 1'b1, "R5 gal mask msb");

    // zero seed corrected (R3)
    step(1'b1, 4'b0000, 4'b1100, 1'b0, 1'b0, "R3 zero seed");
    for (int k = 0; k < 5; k++) step(1'b0, '0, '0, 1'b0, 1'b1, "R3 run from one");

    // hold (R6)
    for (int k = 0; k < 4; k++) step(1'b0, 4'b1111, 4'b1111, 1'b1, 1'b0, "R6 hold");

    // load wins over advance (R2)
    step(1'b1, 4'b1001, 4'b1100, 1'b0, 1'b1, "R2 load priority");
    step(1'b1, 4'b0111, 4'b1011, 1'b1, 1'b0, "R2 reload");

    // inputs wiggled without load (R10)
    for (int k = 0; k < 10; k++)
      step(1'b0, 4'(k), 4'(k * 5), k[0], 1'b1, "R10 no capture");

    // all-ones with only the top tap, external form (R4, R7)
    step(1'b1, 4'b1111, 4'b0000, 1'b0, 1'b0, "R7 load ones");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, 1'b1, "R7 R4 top tap only");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule